// File: doc/BRIEF.md
# Programmable Serial Stress Pattern Generator

This block drives the serial input of a long chain of registers with a repeating bit pattern. The pattern controls how often each downstream register toggles. A 3-bit length code selects the pattern period, and a 1-bit shape input selects one of two pattern families. That gives sixteen settings.

The "pulse" family puts a single 1 in each period of zeros, so it gives two transitions per period. The "wave" family sends a run of ones followed by an equal run of zeros. Its period is twice as long, so it toggles at half the pulse rate.

Internally a nine-stage recirculating register is used. A tap multiplexer picks which stage feeds back to the head, and this sets the period. For the wave family the fed-back bit is inverted. The register advances only on cycles where the active-low shift enable is low. A synchronous reset or a synchronous reload puts the register into the starting state for the current settings.

Top module: `ssp_gen`

## Requirements
- R1: With `pat_type` = 0 and a length code L, `ser_out` repeats with period N and is 1 for exactly one shift position in each period. The period N is 2, 3, 5, 6, 7, 8, 9 for L = 000, 001, 011, 100, 101, 110, 111. After k enabled shifts from the starting state, the output is 1 exactly when k mod N = N-1.
- R2: Length code 010 behaves exactly like code 000 (period 2) for both pattern types.
- R3: With `pat_type` = 1, `ser_out` repeats with period 2N: N ones, then N zeros. After k enabled shifts from the starting state, the output is 1 exactly when (k mod 2N) >= N.
- R4: The register shifts only on clock edges where `shift_en_n` is 0. On any other edge, the state and `ser_out` stay unchanged.
- R5: A cycle with `rst` = 1 loads the starting state for the current `len_code` and `pat_type`. In that state `ser_out` is 0 and the pattern restarts at shift count 0.
- R6: A cycle with `reload` = 1 loads the same starting state as reset, even if `shift_en_n` is 0 in that cycle.
- R7: Over 2N enabled shifts, `ser_out` makes 4 transitions for `pat_type` = 0 and 2 transitions for `pat_type` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the starting state |
| reload | input | 1 | Synchronous reload of the starting state for the current settings |
| shift_en_n | input | 1 | Active-low shift enable |
| len_code | input | 3 | Pattern length code |
| pat_type | input | 1 | 0 = single pulse per period, 1 = half ones / half zeros |
| ser_out | output | 1 | Serial pattern bit |

## Verification
All eight length codes are run under both pattern types, each for several full periods, and compared bit by bit against a closed-form expectation. These runs separate the tap selection (the period) from the feedback inversion (the shape). Code 010 is checked against period-2 behaviour, which shows that the invalid code falls back to the shortest length. A run with an irregular enable pattern shows that gating stalls the sequence and does not skip it. Reset and reload issued in the middle of a sequence, with enable held low, show that the sequence restarts at count zero. Transition counts over two periods confirm the two toggle-rate families.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int MAX_LEN = 9;
    localparam int CODE_W  = 3;
    localparam int TAP_W   = $clog2(MAX_LEN);

    typedef enum logic {
        PAT_PULSE = 1'b0,
        PAT_WAVE  = 1'b1
    } pat_kind_e;

    typedef struct packed {
        logic [TAP_W-1:0] tap;
        logic             invert;
    } fb_cfg_t;

    // Pattern length for a code; the unused code 010 falls back to 2.
    function automatic logic [TAP_W-1:0] len_of_code(input logic [CODE_W-1:0] code);
        logic [TAP_W-1:0] n;
        case (code)
            3'b000:  n = TAP_W'(2);
            3'b001:  n = TAP_W'(3);
            3'b010:  n = TAP_W'(2);
            3'b011:  n = TAP_W'(5);
            3'b100:  n = TAP_W'(6);
            3'b101:  n = TAP_W'(7);
            3'b110:  n = TAP_W'(8);
            default: n = TAP_W'(9);
        endcase
        return n;
    endfunction

    // Starting chain contents: a single 1 at the head for pulses, all zero for waves.
    function automatic logic [MAX_LEN-1:0] start_state(input pat_kind_e kind);
        logic [MAX_LEN-1:0] v;
        v = '0;
        if (kind == PAT_PULSE) begin
            v[0] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/ssp_cfg_decode.sv
module ssp_cfg_decode
    import ssp_pkg::*;
(
    input  logic [CODE_W-1:0]  len_code,
    input  logic               pat_type,
    output fb_cfg_t            cfg,
    output logic [MAX_LEN-1:0] preload
);

    pat_kind_e kind;

    always_comb begin
        kind       = pat_kind_e'(pat_type);
        cfg.tap    = len_of_code(len_code) - TAP_W'(1);
        cfg.invert = (kind == PAT_WAVE);
        preload    = start_state(kind);
    end

endmodule

// File: rtl/ssp_chain.sv
module ssp_chain #(
    parameter int DEPTH = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DEPTH-1:0] load_val,
    input  logic             shift_en_n,
    input  logic             fb_in,
    output logic [DEPTH-1:0] stages
);

    logic [DEPTH-1:0] nxt;

    always_comb begin
        nxt[0] = fb_in;
    end

    genvar i;
    generate
        for (i = 1; i < DEPTH; i++) begin : g_link
            always_comb begin
                nxt[i] = stages[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || load) begin
            stages <= load_val;
        end else if (!shift_en_n) begin
            stages <= nxt;
        end
    end

endmodule

// File: rtl/ssp_tap_mux.sv
module ssp_tap_mux
    import ssp_pkg::*;
(
    input  logic [MAX_LEN-1:0] stages,
    input  fb_cfg_t            cfg,
    output logic               tap_bit,
    output logic               fb_bit
);

    always_comb begin
        tap_bit = 1'b0;
        for (int i = 0; i < MAX_LEN; i++) begin
            if (cfg.tap == TAP_W'(i)) begin
                tap_bit = stages[i];
            end
        end
        fb_bit = tap_bit ^ cfg.invert;
    end

endmodule

// File: rtl/ssp_gen.sv
module ssp_gen
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reload,
    input  logic              shift_en_n,
    input  logic [CODE_W-1:0] len_code,
    input  logic              pat_type,
    output logic              ser_out
);

    fb_cfg_t            cfg;
    logic [MAX_LEN-1:0] preload;
    logic [MAX_LEN-1:0] chain_q;
    logic [TAP_W-1:0]   tap_idx;
    logic               tap_bit;
    logic               fb_bit;

    ssp_cfg_decode u_decode (
        .len_code (len_code),
        .pat_type (pat_type),
        .cfg      (cfg),
        .preload  (preload)
    );

    ssp_chain #(.DEPTH(MAX_LEN)) u_chain (
        .clk        (clk),
        .rst        (rst),
        .load       (reload),
        .load_val   (preload),
        .shift_en_n (shift_en_n),
        .fb_in      (fb_bit),
        .stages     (chain_q)
    );

    ssp_tap_mux u_mux (
        .stages  (chain_q),
        .cfg     (cfg),
        .tap_bit (tap_bit),
        .fb_bit  (fb_bit)
    );

    assign tap_idx = cfg.tap;
    assign ser_out = tap_bit;

endmodule

// File: rtl/ssp_gen_checker.sv
module ssp_gen_checker
    import ssp_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               reload,
    input logic               shift_en_n,
    input logic [CODE_W-1:0]  len_code,
    input logic               ser_out,
    input logic [MAX_LEN-1:0] chain_q,
    input logic [TAP_W-1:0]   tap_idx
);

    a_r5_reset_start: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !ser_out);

    a_r6_reload_start: assert property (@(posedge clk) disable iff (rst)
        reload |=> !ser_out);

    a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        (shift_en_n && !reload) |=> $stable(chain_q));

    a_r4_advance_when_enabled: assert property (@(posedge clk) disable iff (rst)
        (!shift_en_n && !reload) |=> chain_q[MAX_LEN-1:1] == $past(chain_q[MAX_LEN-2:0]));

    a_r1_tap_in_range: assert property (@(posedge clk) disable iff (rst)
        (tap_idx >= TAP_W'(1)) && (tap_idx <= TAP_W'(MAX_LEN-1)));

    a_r2_invalid_code_len2: assert property (@(posedge clk) disable iff (rst)
        (len_code == 3'b010) |-> (tap_idx == TAP_W'(1)));

endmodule

bind ssp_gen ssp_gen_checker u_ssp_gen_checker (
    .clk        (clk),
    .rst        (rst),
    .reload     (reload),
    .shift_en_n (shift_en_n),
    .len_code   (len_code),
    .ser_out    (ser_out),
    .chain_q    (chain_q),
    .tap_idx    (tap_idx)
);

// File: tb/ssp_gen_bench.sv
module ssp_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reload = 1'b0;
    logic       shift_en_n = 1'b1;
    logic [2:0] len_code = 3'b000;
    logic       pat_type = 1'b0;
    logic       ser_out;

    int checks = 0;
    int fails  = 0;

    ssp_gen u_ssp_gen (
        .clk        (clk),
        .rst        (rst),
        .reload     (reload),
        .shift_en_n (shift_en_n),
        .len_code   (len_code),
        .pat_type   (pat_type),
        .ser_out    (ser_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int period_of(input logic [2:0] c);
        case (c)
            3'b001:  return 3;
            3'b011:  return 5;
            3'b100:  return 6;
            3'b101:  return 7;
            3'b110:  return 8;
            3'b111:  return 9;
            default: return 2;
        endcase
    endfunction

    function automatic logic want_bit(input int n, input logic t, input int k);
        if (!t) return ((k % n) == n - 1);
        return ((k % (2 * n)) >= n);
    endfunction

    task automatic check(input string req, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reload with enable held low, then compare a run of enabled shifts.
    task automatic run_pattern(input logic [2:0] code, input logic t, input string req);
        int n;
        int bad;
        int act;
        int exp;
        n   = period_of(code);
        bad = -1;
        act = 0;
        exp = 0;
        @(negedge clk);
        len_code   = code;
        pat_type   = t;
        reload     = 1'b1;
        shift_en_n = 1'b0;
        @(negedge clk);
        reload = 1'b0;
        for (int k = 0; k < 6 * n; k++) begin
            if (bad < 0 && ser_out !== want_bit(n, t, k)) begin
                bad = k;
                act = int'(ser_out);
                exp = int'(want_bit(n, t, k));
            end
            @(negedge clk);
        end
        shift_en_n = 1'b1;
        check(req, bad < 0, act, exp);
    endtask

    task automatic test_reset_state();
        @(negedge clk);
        check("R5 reset output", ser_out === 1'b0, int'(ser_out), 0);
    endtask

    task automatic test_all_codes();
        for (int c = 0; c < 8; c++) begin
            if (c != 2) begin
                run_pattern(3'(c), 1'b0, "R1 pulse sequence");
                run_pattern(3'(c), 1'b1, "R3 wave sequence");
            end
        end
    endtask

    task automatic test_invalid_code();
        run_pattern(3'b010, 1'b0, "R2 code 010 pulse as length 2");
        run_pattern(3'b010, 1'b1, "R2 code 010 wave as length 2");
    endtask

    task automatic test_gating();
        int cnt;
        int bad;
        int act;
        cnt = 0;
        bad = -1;
        act = 0;
        @(negedge clk);
        len_code = 3'b101;
        pat_type = 1'b1;
        reload   = 1'b1;
        @(negedge clk);
        reload = 1'b0;
        for (int i = 0; i < 60; i++) begin
            if (bad < 0 && ser_out !== want_bit(7, 1'b1, cnt)) begin
                bad = i;
                act = int'(ser_out);
            end
            shift_en_n = !((i % 3 == 0) || (i % 7 == 1));
            if (!shift_en_n) cnt++;
            @(negedge clk);
        end
        shift_en_n = 1'b1;
        check("R4 gated shifting", bad < 0, act, int'(want_bit(7, 1'b1, cnt)));
        cnt = int'(ser_out);
        repeat (5) @(negedge clk);
        check("R4 hold while disabled", ser_out === cnt[0], int'(ser_out), cnt);
    endtask

    task automatic test_restart(input logic use_rst, input string req);
        @(negedge clk);
        len_code   = 3'b110;
        pat_type   = 1'b0;
        reload     = 1'b1;
        @(negedge clk);
        reload     = 1'b0;
        shift_en_n = 1'b0;
        repeat (7) @(negedge clk);
        check({req, " mid-run output high"}, ser_out === 1'b1, int'(ser_out), 1);
        if (use_rst) rst = 1'b1; else reload = 1'b1;
        @(negedge clk);
        rst    = 1'b0;
        reload = 1'b0;
        check({req, " restart output"}, ser_out === 1'b0, int'(ser_out), 0);
        repeat (7) @(negedge clk);
        check({req, " restart count"}, ser_out === 1'b1, int'(ser_out), 1);
        shift_en_n = 1'b1;
    endtask

    task automatic test_rate(input logic [2:0] code, input logic t, input int exp_tr);
        int n;
        int tr;
        logic prev;
        n  = period_of(code);
        tr = 0;
        @(negedge clk);
        len_code   = code;
        pat_type   = t;
        reload     = 1'b1;
        shift_en_n = 1'b0;
        @(negedge clk);
        reload = 1'b0;
        repeat (3 * n) @(negedge clk);
        prev = ser_out;
        for (int k = 0; k < 2 * n; k++) begin
            @(negedge clk);
            if (ser_out !== prev) tr++;
            prev = ser_out;
        end
        shift_en_n = 1'b1;
        check("R7 transitions over 2N shifts", tr == exp_tr, tr, exp_tr);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset_state();
        test_all_codes();
        test_invalid_code();
        test_gating();
        test_restart(1'b1, "R5");
        test_restart(1'b0, "R6");
        test_rate(3'b111, 1'b0, 4);
        test_rate(3'b111, 1'b1, 2);
        test_rate(3'b001, 1'b0, 4);
        test_rate(3'b100, 1'b1, 2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule